// File: doc/BRIEF.md
# Embedded Timing Reference Code Inserter

This block takes a 16-bit YCbCr 4:2:2 pixel stream with its own vertical sync and data-enable strobes and produces a 16-bit stream in which the line and frame timing travel inside the data. Luma is on one byte lane and chroma is on the other. Around every line the block writes a four-word end-of-active-video code and a four-word start-of-active-video code. It puts blanking levels everywhere else outside the active picture and passes active pixels through after one register stage. The output is single data rate: one 16-bit word per pixel clock. The default geometry is 1280x720 progressive in a 1650 x 750 raster.

Each code word goes onto both byte lanes in the same clock, so a code sequence takes four pixel clocks. Horizontal position comes from the data-enable strobe. Its rising edge marks pixel 0 of a line. After that a free-running counter predicts where the next start code must go, which is before the enable rises again. Line numbering restarts at the first data-enable rising edge that follows a rising edge of vertical sync. The block emits no codes until that event has happened once.

Top module: `esc_inserter`

## Requirements
- R1: After reset, and until the first data-enable rising edge that follows a vertical-sync rising edge (the frame start), both outputs carry blanking levels: luma 0x10 and chroma 0x80.
- R2: Every code is the word sequence 0xFF, 0x00, 0x00, then a status word, in four consecutive clocks. Each word appears on both byte lanes at once.
- R3: The end code takes the four output slots immediately after the last active pixel of each line, at pixel positions H_ACTIVE to H_ACTIVE+3, counting the first active pixel as position 0.
- R4: The start code takes the four slots immediately before the first active pixel, at positions H_TOTAL-4 to H_TOTAL-1. It is emitted on every line once the frame start has been seen.
- R5: The status word has bit 7 = 1, bit 6 = F = 0, bit 5 = V and bit 4 = H (1 for the end code, 0 for the start code). Bit 3 is V^H, bit 2 is F^H, bit 1 is F^V and bit 0 is F^V^H. This gives 0x80, 0x9D, 0xAB and 0xB6 for (V,H) = 00, 01, 10, 11.
- R6: Lines are numbered 0 to V_TOTAL-1 from the frame start. V is 1 on lines V_ACTIVE and above. An end code carries the V of its own line, and a start code carries the V of the line that follows it.
- R7: After the frame start, every blanking slot that is not a code slot outputs luma 0x10 and chroma 0x80. This includes pixel positions below H_ACTIVE on lines V_ACTIVE and above.
- R8: Active pixels (line below V_ACTIVE, position below H_ACTIVE) appear unchanged on the outputs exactly one clock after they are presented.
- R9: In active pixels each lane is clipped on its own: an input byte of 0x00 becomes 0x01 and 0xFF becomes 0xFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_de | input | 1 | Data enable, high on active pixels |
| vid_vs | input | 1 | Vertical sync, rising edge arms the frame start |
| vid_y | input | 8 | Input luma byte |
| vid_c | input | 8 | Input chroma byte |
| code_y | output | 8 | Output luma lane with embedded codes |
| code_c | output | 8 | Output chroma lane with embedded codes |

## Verification
A wrong pixel-position counter shows up in the same line. A code preamble lands in the wrong slot, or a blanking word replaces a pixel, and the first mismatch appears within one line of the fault. A wrong line counter or V flag shows up only in the status word, so the bench checks every status byte of every line against a table of the four valid values. Without that table, a fault could hide until the frame boundary. A lost lock or a clipping fault is seen on the very next output word.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        SLOT_BLANK,
        SLOT_ACTIVE,
        SLOT_EAV,
        SLOT_SAV
    } slot_e;

    localparam logic [7:0] BLANK_LUMA   = 8'h10;
    localparam logic [7:0] BLANK_CHROMA = 8'h80;

    // Status byte: 1, F, V, H, then four protection bits.
    function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Keep video data clear of the preamble values.
    function automatic logic [7:0] clip_byte(input logic [7:0] b);
        if (b == 8'h00) return 8'h01;
        if (b == 8'hFF) return 8'hFE;
        return b;
    endfunction

endpackage

// File: rtl/esc_timing.sv
module esc_timing
    import esc_pkg::*;
#(
    parameter int H_TOTAL  = 1650,
    parameter int H_ACTIVE = 1280,
    parameter int V_TOTAL  = 750,
    parameter int V_ACTIVE = 720
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        de_i,
    input  logic        vs_i,
    output slot_e       slot_o,
    output logic [1:0]  idx_o,
    output logic        vbit_o
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_TOT_M1 = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT_W  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_EAV_E  = HW'(H_ACTIVE + 4);
    localparam logic [HW-1:0] H_SAV_W  = HW'(H_TOTAL - 4);
    localparam logic [VW-1:0] V_TOT_M1 = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_ACT_W  = VW'(V_ACTIVE);

    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic [VW-1:0] lcnt;
        logic          de_prev;
        logic          vs_prev;
        logic          vs_seen;
        logic          locked;
    } state_t;

    state_t s_d, s_q;

    logic          de_rise, frame_start, locked_now;
    logic [HW-1:0] pos, off;
    logic [VW-1:0] cur_line, nxt_line;

    always_comb begin
        de_rise     = de_i & ~s_q.de_prev;
        frame_start = de_rise & s_q.vs_seen;
        locked_now  = s_q.locked | frame_start;
        pos         = de_rise ? '0 : s_q.hcnt;

        if (frame_start)
            cur_line = '0;
        else if (pos == '0)
            cur_line = (s_q.lcnt == V_TOT_M1) ? '0 : s_q.lcnt + VW'(1);
        else
            cur_line = s_q.lcnt;
        nxt_line = (cur_line == V_TOT_M1) ? '0 : cur_line + VW'(1);

        s_d.hcnt    = (pos == H_TOT_M1) ? '0 : pos + HW'(1);
        s_d.lcnt    = cur_line;
        s_d.de_prev = de_i;
        s_d.vs_prev = vs_i;
        s_d.vs_seen = frame_start ? 1'b0 : (s_q.vs_seen | (vs_i & ~s_q.vs_prev));
        s_d.locked  = locked_now;

        slot_o = SLOT_BLANK;
        off    = '0;
        vbit_o = 1'b0;
        if (locked_now) begin
            if (pos < H_ACT_W && cur_line < V_ACT_W) begin
                slot_o = SLOT_ACTIVE;
            end else if (pos >= H_ACT_W && pos < H_EAV_E) begin
                slot_o = SLOT_EAV;
                off    = pos - H_ACT_W;
                vbit_o = (cur_line >= V_ACT_W);
            end else if (pos >= H_SAV_W) begin
                slot_o = SLOT_SAV;
                off    = pos - H_SAV_W;
                vbit_o = (nxt_line >= V_ACT_W);
            end
        end
        idx_o = off[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.hcnt    <= '0;
            s_q.lcnt    <= V_TOT_M1;
            s_q.de_prev <= 1'b0;
            s_q.vs_prev <= 1'b0;
            s_q.vs_seen <= 1'b0;
            s_q.locked  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1: once aligned to a frame, the block stays aligned
    p_lock_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.locked |=> s_q.locked);

    // R6: the line number moves only when the pixel position restarts
    p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lcnt != $past(s_q.lcnt)) |-> (s_q.hcnt == HW'(1)));

endmodule

// File: rtl/esc_formatter.sv
module esc_formatter
    import esc_pkg::*;
#(
    parameter logic F_BIT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slot_e      slot_i,
    input  logic [1:0] idx_i,
    input  logic       vbit_i,
    input  logic [7:0] y_i,
    input  logic [7:0] c_i,
    output logic [7:0] y_o,
    output logic [7:0] c_o
);
    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
        logic       act;
    } out_t;

    out_t o_d, o_q;
    logic [7:0] code_word;

    always_comb begin
        case (idx_i)
            2'd0:    code_word = 8'hFF;
            2'd3:    code_word = status_byte(F_BIT, vbit_i, slot_i == SLOT_EAV);
            default: code_word = 8'h00;
        endcase

        o_d.act = 1'b0;
        case (slot_i)
            SLOT_ACTIVE: begin
                o_d.y   = clip_byte(y_i);
                o_d.c   = clip_byte(c_i);
                o_d.act = 1'b1;
            end
            SLOT_EAV, SLOT_SAV: begin
                o_d.y = code_word;
                o_d.c = code_word;
            end
            default: begin
                o_d.y = BLANK_LUMA;
                o_d.c = BLANK_CHROMA;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q.y   <= BLANK_LUMA;
            o_q.c   <= BLANK_CHROMA;
            o_q.act <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign y_o = o_q.y;
    assign c_o = o_q.c;

    // R9: active words never carry a preamble value
    p_active_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.act |-> (o_q.y != 8'h00 && o_q.y != 8'hFF && o_q.c != 8'h00 && o_q.c != 8'hFF));

    // R3: the first slot after the active run opens an end code
    p_eav_after_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(o_q.act) |-> (o_q.y == 8'hFF));

endmodule

// File: rtl/esc_inserter.sv
module esc_inserter
    import esc_pkg::*;
#(
    parameter int H_TOTAL  = 1650,
    parameter int H_ACTIVE = 1280,
    parameter int V_TOTAL  = 750,
    parameter int V_ACTIVE = 720
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vid_de,
    input  logic       vid_vs,
    input  logic [7:0] vid_y,
    input  logic [7:0] vid_c,
    output logic [7:0] code_y,
    output logic [7:0] code_c
);
    slot_e      slot;
    logic [1:0] idx;
    logic       vbit;

    esc_timing #(
        .H_TOTAL (H_TOTAL),
        .H_ACTIVE(H_ACTIVE),
        .V_TOTAL (V_TOTAL),
        .V_ACTIVE(V_ACTIVE)
    ) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .de_i  (vid_de),
        .vs_i  (vid_vs),
        .slot_o(slot),
        .idx_o (idx),
        .vbit_o(vbit)
    );

    esc_formatter #(
        .F_BIT(1'b0)
    ) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .slot_i(slot),
        .idx_i (idx),
        .vbit_i(vbit),
        .y_i   (vid_y),
        .c_i   (vid_c),
        .y_o   (code_y),
        .c_o   (code_c)
    );

    // R2: both lanes carry the preamble together
    p_lanes_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_y == 8'hFF) |-> (code_c == 8'hFF));

    // R2: a preamble is followed by two zero words and a status word
    p_code_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_y == 8'hFF) |=> (code_y == 8'h00 && code_c == 8'h00)
            ##1 (code_y == 8'h00 && code_c == 8'h00)
            ##1 (code_y[7] && code_y == code_c));

endmodule

// File: tb/esc_inserter_test.sv
module esc_inserter_test;
    localparam int HT = 32;
    localparam int HA = 16;
    localparam int VT = 10;
    localparam int VA = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vid_de = 1'b0;
    logic       vid_vs = 1'b0;
    logic [7:0] vid_y = 8'h00;
    logic [7:0] vid_c = 8'h00;
    logic [7:0] code_y, code_c;

    always #4 clk = ~clk;

    esc_inserter #(.H_TOTAL(HT), .H_ACTIVE(HA), .V_TOTAL(VT), .V_ACTIVE(VA)) uut (
        .clk(clk), .rst_n(rst_n), .vid_de(vid_de), .vid_vs(vid_vs),
        .vid_y(vid_y), .vid_c(vid_c), .code_y(code_y), .code_c(code_c)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    task automatic check(input string req, input logic [7:0] ey, input logic [7:0] ec);
        checks++;
        if (code_y !== ey || code_c !== ec) begin
            fails++;
            $display("FAIL %s: got y=%02h c=%02h, expected y=%02h c=%02h", req, code_y, code_c, ey, ec);
        end
    endtask

    // Valid status bytes for progressive video, from the R5 table
    function automatic logic [7:0] ref_status(input bit v, input bit h);
        case ({v, h})
            2'b00:   return 8'h80;
            2'b01:   return 8'h9D;
            2'b10:   return 8'hAB;
            default: return 8'hB6;
        endcase
    endfunction

    function automatic logic [7:0] ref_clip(input logic [7:0] b);
        return (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit          pending = 0;
        logic [7:0]  ey = 8'h00, ec = 8'h00;
        string       ereq = "";
        bit          locked = 0, vs_prev = 0, vs_seen = 0;

        repeat (3) @(negedge clk);
        check("R1 reset", 8'h10, 8'h80);
        rst_n = 1'b1;

        for (int l = 0; l < 4 + 3 * VT; l++) begin
            for (int x = 0; x < HT; x++) begin
                int   y;
                bit   de, vs;
                logic [7:0] py, pc;
                @(negedge clk);
                if (pending) check(ereq, ey, ec);

                y  = (VA + l) % VT;
                de = (y < VA) && (x < HA);
                vs = (y == 7) || (y == 8);
                py = (x == 1) ? 8'h00 : (x == 2) ? 8'hFF : 8'((l * 53 + x * 29 + 7));
                pc = (x == 3) ? 8'hFF : (x == 4) ? 8'h00 : 8'((l * 17 + x * 71 + 3));
                vid_de = de; vid_vs = vs; vid_y = py; vid_c = pc;

                if (vs && !vs_prev) vs_seen = 1;
                if (de && x == 0 && vs_seen) begin locked = 1; vs_seen = 0; end
                vs_prev = vs;

                if (!locked) begin
                    ereq = "R1 pre-lock"; ey = 8'h10; ec = 8'h80;
                end else if (de) begin
                    ereq = (py == 8'h00 || py == 8'hFF || pc == 8'h00 || pc == 8'hFF) ? "R9 clip" : "R8 active";
                    ey = ref_clip(py); ec = ref_clip(pc);
                end else if (x >= HA && x < HA + 4) begin
                    ereq = (x == HA + 3) ? "R3 R5 R6 end status" : "R2 R3 end preamble";
                    ey = (x == HA) ? 8'hFF : (x == HA + 3) ? ref_status(y >= VA, 1) : 8'h00;
                    ec = ey;
                end else if (x >= HT - 4) begin
                    ereq = (x == HT - 1) ? "R4 R5 R6 start status" : "R2 R4 start preamble";
                    ey = (x == HT - 4) ? 8'hFF : (x == HT - 1) ? ref_status(((y + 1) % VT) >= VA, 0) : 8'h00;
                    ec = ey;
                end else begin
                    ereq = "R7 blanking"; ey = 8'h10; ec = 8'h80;
                end
                pending = 1;
            end
        end
        @(negedge clk);
        check(ereq, ey, ec);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule